// File: doc/BRIEF.md
# LED Chaser with Round Counter

This block drives a row of LEDs through repeating rounds. Each round starts with a chase: the LEDs light one at a time, from the first in the row to the last, each for a fixed slot. When the last slot ends, a round counter goes up by one. Its value is then shown in binary on the same LEDs for a longer display period, and the next round follows.

An active-low pushbutton toggles a pause mode. The button passes through a synchroniser and a periodic sampling debouncer. While paused, the counter holds its value, the display period is skipped and the chases run back to back. All durations are parameters in clock cycles, so a bench can shrink them.

Top module: `led_round_chaser`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `led` is `1000`: only the first LED, `led[3]`, is lit. The round count is 0 and pause mode is off.
- R2: A chase lights exactly one LED at a time, in the order `led[3]`, `led[2]`, `led[1]`, `led[0]`. Each LED stays lit for SLOT_CYC cycles.
- R3: When the slot of `led[0]` ends and pause mode is off, the round count rises by one. The LEDs then show the new count in binary for SHOW_CYC cycles, with `led[0]` as the least significant bit and `led[3]` as the most significant bit. After that the next chase starts at `led[3]`.
- R4: The round count runs from 0 to 15 and then wraps to 0, so the round after the one showing 15 shows `0000`.
- R5: `led` comes straight from a register. It changes only on the cycle in which a slot or display period ends.
- R6: When the slot of `led[0]` ends in pause mode, no display is shown. The next chase starts on the following cycle and the round count keeps its value.
- R7: The pause key is active low and is synchronised by two flops. It is sampled once every SAMPLE_CYC cycles. A press is a sample of 1 followed by a sample of 0, and each press toggles pause mode. Bounce shorter than SAMPLE_CYC cycles gives exactly one toggle per press.
- R8: Pause mode is read only when the slot of `led[0]` ends. A press during a display period does not shorten that display. After pause mode is left, the next display shows the held count plus one.
- R9: A reset in the middle of a run clears both the round count and pause mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pause_key_n | input | 1 | Raw pause pushbutton, low when pressed, may bounce |
| led | output | NUM_LED | LED drive, 1 = lit, `led[NUM_LED-1]` is the first LED in the row |

## Verification
The bench first runs a long stretch of rounds with no key activity, so that the count reaches 15 and wraps. It then runs a seeded random mix of idle rounds and presses. The presses have random bounce before the key settles low and again when it is released, and they land either in a chase or in a display. This separates a toggle that takes effect at the round boundary from one that cuts a display short, and it shows whether bounce causes a double toggle. The bench compares every cycle against a round model built from the requirements, so a wrong slot length, LED order or binary value shows up at once. A reset applied while paused shows whether both the pause mode and the count are cleared.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_HOLD = 1'b1
    } run_mode_e;
endpackage

// File: rtl/lrc_debounce.sv
module lrc_debounce #(
    parameter int SAMPLE_CYC = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_n,
    output logic press
);
    localparam int SW = (SAMPLE_CYC > 2) ? $clog2(SAMPLE_CYC) : 1;

    typedef struct packed {
        logic [1:0]    sync;
        logic [SW-1:0] div;
        logic          smp;
        logic          press;
    } deb_t;

    deb_t q, d;

    always_comb begin
        d          = q;
        d.sync     = {q.sync[0], key_n};
        d.press    = 1'b0;
        if (q.div == SW'(SAMPLE_CYC - 1)) begin
            d.div   = '0;
            d.smp   = q.sync[1];
            d.press = q.smp & ~q.sync[1];
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync  <= 2'b11;
            q.div   <= '0;
            q.smp   <= 1'b1;
            q.press <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign press = q.press;

    // a press pulse only follows a sampling instant
    assert_press_on_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.press |-> $past(q.div) == SW'(SAMPLE_CYC - 1));
endmodule

// File: rtl/lrc_sequencer.sv
module lrc_sequencer #(
    parameter int NUM_LED  = 4,
    parameter int SLOT_CYC = 12_500_000,
    parameter int SHOW_CYC = 100_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    output logic [NUM_LED-1:0] led
);
    localparam int PW      = $clog2(NUM_LED + 1);
    localparam int LONGEST = (SLOT_CYC > SHOW_CYC) ? SLOT_CYC : SHOW_CYC;
    localparam int TW      = (LONGEST > 2) ? $clog2(LONGEST) : 1;
    localparam logic [PW-1:0] SHOW_PH = PW'(NUM_LED);
    localparam logic [PW-1:0] LAST_PH = PW'(NUM_LED - 1);
    localparam logic [NUM_LED-1:0] FIRST = {1'b1, {(NUM_LED-1){1'b0}}};

    typedef struct packed {
        logic [PW-1:0]      ph;
        logic [TW-1:0]      tmr;
        logic [NUM_LED-1:0] cnt;
        logic [NUM_LED-1:0] led;
    } seq_t;

    seq_t q, d;
    logic at_end;

    always_comb begin
        d      = q;
        at_end = (q.ph == SHOW_PH) ? (q.tmr == TW'(SHOW_CYC - 1))
                                   : (q.tmr == TW'(SLOT_CYC - 1));
        if (!at_end) begin
            d.tmr = q.tmr + 1'b1;
        end else begin
            d.tmr = '0;
            if (q.ph == SHOW_PH) begin
                d.ph  = '0;
                d.led = FIRST;
            end else if (q.ph == LAST_PH) begin
                if (hold) begin
                    d.ph  = '0;
                    d.led = FIRST;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                    d.ph  = SHOW_PH;
                    d.led = q.cnt + 1'b1;
                end
            end else begin
                d.ph  = q.ph + 1'b1;
                d.led = q.led >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph  <= '0;
            q.tmr <= '0;
            q.cnt <= '0;
            q.led <= FIRST;
        end else begin
            q <= d;
        end
    end

    assign led = q.led;

    assert_chase_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph != SHOW_PH) |-> $countones(q.led) == 1);

    assert_show_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == SHOW_PH) |-> q.led == q.cnt);

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != $past(q.cnt)) |-> q.cnt == NUM_LED'($past(q.cnt) + 1'b1));

    assert_led_only_at_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.tmr != '0) |-> $stable(q.led));

    assert_hold_skips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == LAST_PH && q.tmr == TW'(SLOT_CYC - 1) && hold)
        |=> (q.ph == '0 && $stable(q.cnt)));
endmodule

// File: rtl/led_round_chaser.sv
module led_round_chaser #(
    parameter int NUM_LED    = 4,
    parameter int SLOT_CYC   = 12_500_000,
    parameter int SHOW_CYC   = 100_000_000,
    parameter int SAMPLE_CYC = 1_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pause_key_n,
    output logic [NUM_LED-1:0] led
);
    import lrc_pkg::*;

    typedef struct packed {
        run_mode_e mode;
    } top_t;

    top_t q, d;
    logic press;

    lrc_debounce #(.SAMPLE_CYC(SAMPLE_CYC)) u_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .key_n (pause_key_n),
        .press (press)
    );

    always_comb begin
        d = q;
        if (press) begin
            d.mode = (q.mode == MODE_RUN) ? MODE_HOLD : MODE_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode <= MODE_RUN;
        end else begin
            q <= d;
        end
    end

    lrc_sequencer #(
        .NUM_LED  (NUM_LED),
        .SLOT_CYC (SLOT_CYC),
        .SHOW_CYC (SHOW_CYC)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (q.mode == MODE_HOLD),
        .led   (led)
    );

    assert_press_toggles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> q.mode != $past(q.mode));

    assert_mode_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(press) |-> $stable(q.mode));
endmodule

// File: tb/led_round_chaser_bench.sv
module led_round_chaser_bench;
    localparam int SLOT   = 8;
    localparam int SHOW   = 20;
    localparam int SAMPLE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_n = 1'b1;
    logic [3:0] led;

    int   n_cmp = 0;
    int   n_bad = 0;
    logic [3:0] ref_cnt = 4'd0;
    bit   exp_hold = 1'b0;
    bit   prev_hold = 1'b0;

    always #4 clk = ~clk;

    led_round_chaser #(
        .NUM_LED(4), .SLOT_CYC(SLOT), .SHOW_CYC(SHOW), .SAMPLE_CYC(SAMPLE)
    ) u_led_round_chaser (
        .clk(clk), .rst_n(rst_n), .pause_key_n(key_n), .led(led)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [3:0] exp);
        n_cmp++;
        if (led !== exp) begin
            n_bad++;
            $display("FAIL %s: led=%b expected %b", tag, led, exp);
        end
    endtask

    function automatic logic [3:0] chase_led(input int idx);
        return 4'b1000 >> idx;
    endfunction

    // press with bounce shorter than one sample period, at most 16 steps
    task automatic press_key();
        int b1 = $urandom_range(0, SAMPLE - 1);
        int b2 = $urandom_range(0, SAMPLE - 1);
        for (int k = 0; k < b1; k++) begin key_n = 1'($urandom_range(0, 1)); step(); end
        key_n = 1'b0;
        repeat (2 * SAMPLE + 2) step();
        for (int k = 0; k < b2; k++) begin key_n = 1'($urandom_range(0, 1)); step(); end
        key_n = 1'b1;
    endtask

    // where: 0 no press, 1 press in chase, 2 press in display
    task automatic run_round(input int where);
        string ctag = prev_hold ? "R6 chase after skip" :
                      (where == 1 ? "R7 chase with bounce" : "R2 R5 chase");
        fork
            begin
                for (int i = 0; i < 4; i++)
                    for (int c = 0; c < SLOT; c++) begin chk(ctag, chase_led(i)); step(); end
            end
            begin
                if (where == 1) press_key();
            end
        join
        if (where == 1) exp_hold = !exp_hold;
        prev_hold = exp_hold;
        if (!exp_hold) begin
            ref_cnt = ref_cnt + 4'd1;
            fork
                begin
                    for (int c = 0; c < SHOW; c++) begin
                        chk(ref_cnt == 4'd0 ? "R4 wrap" :
                            (where == 2 ? "R8 display not cut" : "R3 display"), ref_cnt);
                        step();
                    end
                end
                begin
                    if (where == 2) press_key();
                end
            join
            if (where == 2) exp_hold = !exp_hold;
        end
    endtask

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) step();
        chk("R1 reset", 4'b1000);
        rst_n = 1'b1;
        chk("R1 first cycle", 4'b1000);

        for (int r = 0; r < 17; r++) run_round(0);     // covers wrap (R4)

        run_round(1);                                   // enter pause
        run_round(0);                                   // stays paused (R6)
        run_round(1);                                   // leave: held+1 shown (R8)
        run_round(2);                                   // press in display (R8)
        run_round(0);

        for (int r = 0; r < 30; r++) begin
            int sel = $urandom_range(0, 5);
            if (sel == 0)      run_round(1);
            else if (sel == 1 && !exp_hold) run_round(2);
            else               run_round(0);
        end

        if (!exp_hold) run_round(1);                    // make sure paused
        repeat (5) step();
        rst_n = 1'b0;
        step();
        chk("R9 reset mid-run", 4'b1000);
        step();
        rst_n = 1'b1;
        ref_cnt = 4'd0;
        exp_hold = 1'b0;
        prev_hold = 1'b0;
        run_round(0);                                   // R9: shows 1
        run_round(0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule